// File: doc/BRIEF.md
# Two-Beat 9-Bit Parallel Host Port

This block is the slave side of an 8080-style parallel bus for a display controller whose host uses a 9-line data path. The host drives active-low chip select, a register-select line, and active-low write and read strobes. The block pairs consecutive bus beats into full-width words and hands each finished word to the rest of the controller as a single-cycle strobe in the system clock domain.

Register-select low carries beats for the 16-bit index. Register-select high carries beats for a data word. That data word is 18-bit pixel RAM data when the latched index equals a configurable RAM-write index, and 16-bit instruction data for any other index. Instruction and index beats each carry one byte on the top eight lines. The bottom line is ignored for those beats. RAM beats use all nine lines. In every case the upper part comes first.

For reads, the block returns a 16-bit word supplied by the surrounding logic as two byte beats, upper byte first. The host strobes, select lines and data are brought into the clock domain through synchronizer chains, and data is taken on the synchronized rising edge of the write strobe.

Top module: `beat_pair_host_port`

## Requirements
- R1: The port is active only when `modeSel` equals 3'b001. With any other value, write beats produce no strobe and `dbOe` stays low even while `csN` and `rdN` are both low.
- R2: Two write beats with `rsel` low load the index as {beat1 lines 8..1, beat2 lines 8..1}, with line 0 (DB9) ignored. `idxLoad` pulses after the second beat, including when the upper byte is zero.
- R3: Two write beats with `rsel` high, while the index differs from `RAM_WR_INDEX`, produce `instrData` = {beat1[8:1], beat2[8:1]} with one `instrWrite` pulse.
- R4: Two write beats with `rsel` high, while the index equals `RAM_WR_INDEX` (default 16'h0202), produce `ramData` = {beat1[8:0], beat2[8:0]} with one `ramWrite` pulse.
- R5: A lone first beat produces no strobe and leaves `idxValue` unchanged.
- R6: `csN` going high clears both the write and read beat trackers. A half pair is then dropped, and the next beat counts as a first beat.
- R7: A change of `rsel` between two write beats restarts the tracker. The beat with the new `rsel` becomes a first beat.
- R8: `dbOe` is high only while the mode matches and `csN` and `rdN` are both low. The first read beat drives `dbOut` = {readWord[15:8], 1'b0}, and the second drives {readWord[7:0], 1'b0}.
- R9: The read tracker advances on each rising edge of `rdN`. After two read beats, the next read shows the upper byte again.
- R10: Each strobe is one clock wide, and at most one of `idxLoad`, `instrWrite`, `ramWrite` is high in any cycle.
- R11: After reset, all strobes are low, `idxValue`, `instrData` and `ramData` are zero, and both trackers are at the first beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeSel | input | 3 | Interface mode select; 3'b001 enables this port |
| csN | input | 1 | Host chip select, active low |
| rsel | input | 1 | Register select: low = index, high = data |
| wrN | input | 1 | Host write strobe, active low; data taken on its rise |
| rdN | input | 1 | Host read strobe, active low |
| dbIn | input | 9 | Bus lines DB17..DB9 as bits 8..0 |
| dbOut | output | 9 | Read data on DB17..DB9; bit 0 driven 0 |
| dbOe | output | 1 | Bus output enable during reads |
| readWord | input | 16 | Word returned on reads (instruction or device code) |
| idxValue | output | 16 | Current index register value |
| idxLoad | output | 1 | One-cycle pulse when the index is loaded |
| instrWrite | output | 1 | One-cycle pulse for 16-bit instruction data |
| instrData | output | 16 | Instruction data word |
| ramWrite | output | 1 | One-cycle pulse for an 18-bit RAM word |
| ramData | output | 18 | RAM write word |

## Verification
The bench targets the places where beats can mispair:
- A first beat left hanging when chip select rises. A design that keeps it would merge it with the next pair and strobe on the wrong beat with mixed data.
- An `rsel` switch between beats. Missing that restart turns an index half-byte into instruction data.
- The choice between the 18-bit and 16-bit data layouts, made from the index. A wrong compare or a shifted field shows up as a wrong word or a strobe on the wrong output.
- Read byte order across three reads. A tracker that never wraps or starts on the wrong byte returns the bytes out of order.
- A foreign mode value. This must silence both strobes and the bus driver.

// File: rtl/bph_pkg.sv
package bph_pkg;
  localparam int BEAT_W = 9;
  localparam int WORD_W = 16;
  localparam int RAM_W  = 2 * BEAT_W;

  // strobes from control to datapath
  typedef struct packed {
    logic latchHi;     // store first beat
    logic commitIdx;   // second index beat
    logic commitData;  // second data beat
  } ctrl_t;
endpackage

// File: rtl/bph_sync.sv
module bph_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : gStage
      if (s == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= RESET_VAL;
          else       chain[0] <= din;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= RESET_VAL;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/bph_ctrl.sv
module bph_ctrl
  import bph_pkg::*;
#(
  parameter logic [2:0] MODE_CODE = 3'b001
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] modeSel,
  input  logic       csS,
  input  logic       rsS,
  input  logic       wrS,
  input  logic       rdS,
  output ctrl_t      ctl,
  output logic       rdSecond
);
  logic modeOk, active;
  logic wrPrev, rdPrev;
  logic wrEvent, rdEvent;
  logic wrSecond, beatRs, pairs;

  assign modeOk  = (modeSel == MODE_CODE);
  assign active  = modeOk && !csS;
  assign wrEvent = active && wrS && !wrPrev;
  assign rdEvent = active && rdS && !rdPrev;
  assign pairs   = wrSecond && (rsS == beatRs);

  always_comb begin
    ctl            = '0;
    ctl.latchHi    = wrEvent && !pairs;
    ctl.commitIdx  = wrEvent && pairs && !rsS;
    ctl.commitData = wrEvent && pairs && rsS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPrev   <= 1'b1;
      rdPrev   <= 1'b1;
      wrSecond <= 1'b0;
      rdSecond <= 1'b0;
      beatRs   <= 1'b0;
    end else begin
      wrPrev <= wrS;
      rdPrev <= rdS;
      if (!active) begin
        wrSecond <= 1'b0;
        rdSecond <= 1'b0;
      end else begin
        if (wrEvent) begin
          if (pairs) begin
            wrSecond <= 1'b0;
          end else begin
            wrSecond <= 1'b1;
            beatRs   <= rsS;
          end
        end
        if (rdEvent) rdSecond <= !rdSecond;
      end
    end
  end

  AST_CS_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    csS |=> (!wrSecond && !rdSecond)); // R6
  AST_MODE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !modeOk |=> (!wrSecond && !rdSecond)); // R1
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.latchHi, ctl.commitIdx, ctl.commitData})); // R10
endmodule

// File: rtl/bph_dpath.sv
module bph_dpath
  import bph_pkg::*;
#(
  parameter logic [WORD_W-1:0] RAM_WR_INDEX = 16'h0202
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctl,
  input  logic [BEAT_W-1:0] dS,
  input  logic              rdSecond,
  input  logic [WORD_W-1:0] readWord,
  output logic [WORD_W-1:0] idxValue,
  output logic              idxLoad,
  output logic              instrWrite,
  output logic [WORD_W-1:0] instrData,
  output logic              ramWrite,
  output logic [RAM_W-1:0]  ramData,
  output logic [BEAT_W-1:0] dbOut
);
  localparam int BYTE_W = BEAT_W - 1;

  logic [BEAT_W-1:0] hiBeat;
  logic              ramSel;
  logic [WORD_W-1:0] byteWord;

  assign ramSel   = (idxValue == RAM_WR_INDEX);
  assign byteWord = {hiBeat[BEAT_W-1:1], dS[BEAT_W-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiBeat     <= '0;
      idxValue   <= '0;
      idxLoad    <= 1'b0;
      instrWrite <= 1'b0;
      instrData  <= '0;
      ramWrite   <= 1'b0;
      ramData    <= '0;
    end else begin
      idxLoad    <= 1'b0;
      instrWrite <= 1'b0;
      ramWrite   <= 1'b0;
      if (ctl.latchHi) hiBeat <= dS;
      if (ctl.commitIdx) begin
        idxValue <= byteWord;
        idxLoad  <= 1'b1;
      end
      if (ctl.commitData) begin
        if (ramSel) begin
          ramData  <= {hiBeat, dS};
          ramWrite <= 1'b1;
        end else begin
          instrData  <= byteWord;
          instrWrite <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (rdSecond) dbOut = {readWord[BYTE_W-1:0], 1'b0};
    else          dbOut = {readWord[WORD_W-1:BYTE_W], 1'b0};
  end

  AST_IDX_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    idxLoad |=> !idxLoad); // R10
  AST_EXCL_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({idxLoad, instrWrite, ramWrite})); // R10
  AST_RAM_IDX: assert property (@(posedge clk) disable iff (!rstN)
    ramWrite |-> (idxValue == RAM_WR_INDEX)); // R4
  AST_INSTR_IDX: assert property (@(posedge clk) disable iff (!rstN)
    instrWrite |-> (idxValue != RAM_WR_INDEX)); // R3
endmodule

// File: rtl/beat_pair_host_port.sv
module beat_pair_host_port
  import bph_pkg::*;
#(
  parameter logic [2:0]        MODE_CODE    = 3'b001,
  parameter logic [WORD_W-1:0] RAM_WR_INDEX = 16'h0202,
  parameter int                SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        modeSel,
  input  logic              csN,
  input  logic              rsel,
  input  logic              wrN,
  input  logic              rdN,
  input  logic [BEAT_W-1:0] dbIn,
  output logic [BEAT_W-1:0] dbOut,
  output logic              dbOe,
  input  logic [WORD_W-1:0] readWord,
  output logic [WORD_W-1:0] idxValue,
  output logic              idxLoad,
  output logic              instrWrite,
  output logic [WORD_W-1:0] instrData,
  output logic              ramWrite,
  output logic [RAM_W-1:0]  ramData
);
  logic [3:0]        busS;
  logic [BEAT_W-1:0] dS;
  ctrl_t             ctl;
  logic              rdSecond;

  bph_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RESET_VAL(4'b1011)) uSyncCtl (
    .clk(clk), .rstN(rstN), .din({csN, rsel, wrN, rdN}), .dout(busS));

  bph_sync #(.WIDTH(BEAT_W), .STAGES(SYNC_STAGES), .RESET_VAL('0)) uSyncDat (
    .clk(clk), .rstN(rstN), .din(dbIn), .dout(dS));

  bph_ctrl #(.MODE_CODE(MODE_CODE)) uCtrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel),
    .csS(busS[3]), .rsS(busS[2]), .wrS(busS[1]), .rdS(busS[0]),
    .ctl(ctl), .rdSecond(rdSecond));

  bph_dpath #(.RAM_WR_INDEX(RAM_WR_INDEX)) uDpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dS(dS), .rdSecond(rdSecond),
    .readWord(readWord), .idxValue(idxValue), .idxLoad(idxLoad),
    .instrWrite(instrWrite), .instrData(instrData),
    .ramWrite(ramWrite), .ramData(ramData), .dbOut(dbOut));

  assign dbOe = (modeSel == MODE_CODE) && !csN && !rdN;
endmodule

// File: tb/tb_beat_pair_host_port.sv
`timescale 1ns/1ps
module tb_beat_pair_host_port;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  modeSel = 3'b001;
  logic        csN = 1'b1, rsel = 1'b0, wrN = 1'b1, rdN = 1'b1;
  logic [8:0]  dbIn = '0;
  logic [8:0]  dbOut;
  logic        dbOe;
  logic [15:0] readWord = 16'hBEEF;
  logic [15:0] idxValue, instrData;
  logic        idxLoad, instrWrite, ramWrite;
  logic [17:0] ramData;

  int checks = 0, fails = 0;
  int idxCnt = 0, instrCnt = 0, ramCnt = 0, overlap = 0;
  logic [15:0] lastIdx = '0, lastInstr = '0;
  logic [17:0] lastRam = '0;

  always #2.5 clk = ~clk;

  beat_pair_host_port dut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .csN(csN), .rsel(rsel),
    .wrN(wrN), .rdN(rdN), .dbIn(dbIn), .dbOut(dbOut), .dbOe(dbOe),
    .readWord(readWord), .idxValue(idxValue), .idxLoad(idxLoad),
    .instrWrite(instrWrite), .instrData(instrData),
    .ramWrite(ramWrite), .ramData(ramData));

  always @(negedge clk) begin
    if (rstN) begin
      if (idxLoad)    begin idxCnt++;   lastIdx = idxValue;    end
      if (instrWrite) begin instrCnt++; lastInstr = instrData; end
      if (ramWrite)   begin ramCnt++;   lastRam = ramData;     end
      if (int'(idxLoad) + int'(instrWrite) + int'(ramWrite) > 1) overlap++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic hostWrite(input logic rs, input logic [8:0] d);
    csN = 1'b0; rsel = rs; dbIn = d;
    tick(3);
    wrN = 1'b0;
    tick(4);
    wrN = 1'b1;
    tick(5);
  endtask

  task automatic csHigh();
    csN = 1'b1;
    tick(5);
  endtask

  task automatic hostRead(output logic [8:0] v, output logic oe);
    csN = 1'b0;
    tick(3);
    rdN = 1'b0;
    tick(3);
    v = dbOut; oe = dbOe;
    rdN = 1'b1;
    tick(5);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  typedef struct packed {
    logic        rs;
    logic [8:0]  b1;
    logic [8:0]  b2;
    logic [1:0]  kind;   // 0 index, 1 instruction, 2 RAM
    logic [17:0] val;
  } vec_t;

  localparam vec_t VECS [0:6] = '{
    '{1'b0, 9'h000, 9'h0A5, 2'd0, 18'h00052},   // R2 zero upper byte
    '{1'b1, 9'h187, 9'h078, 2'd1, 18'h0C33C},   // R3
    '{1'b0, 9'h005, 9'h005, 2'd0, 18'h00202},   // R2 select RAM index
    '{1'b1, 9'h1FF, 9'h001, 2'd2, 18'h3FE01},   // R4
    '{1'b1, 9'h0AA, 9'h155, 2'd2, 18'h15555},   // R4
    '{1'b0, 9'h024, 9'h069, 2'd0, 18'h01234},   // R2
    '{1'b1, 9'h1FF, 9'h001, 2'd1, 18'h0FF00}    // R3
  };

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [8:0] rv;
    logic       oe;
    int         i0, s0, r0;
    tick(4);
    rstN = 1'b1;
    tick(2);
    // R11 reset state
    chk(idxValue == 16'h0 && instrData == 16'h0, "R11 idx/instr", {idxValue, instrData}, 0);
    chk(ramData == 18'h0, "R11 ram", ramData, 0);
    chk(!idxLoad && !instrWrite && !ramWrite && !dbOe, "R11 strobes", {idxLoad, instrWrite, ramWrite, dbOe}, 0);

    for (int k = 0; k < 7; k++) begin
      i0 = idxCnt; s0 = instrCnt; r0 = ramCnt;
      hostWrite(VECS[k].rs, VECS[k].b1);
      hostWrite(VECS[k].rs, VECS[k].b2);
      csHigh();
      case (VECS[k].kind)
        2'd0: begin
          chk(idxCnt == i0 + 1 && instrCnt == s0 && ramCnt == r0, "R2 count", idxCnt - i0, 1);
          chk(lastIdx == VECS[k].val[15:0], "R2 value", lastIdx, VECS[k].val);
        end
        2'd1: begin
          chk(instrCnt == s0 + 1 && idxCnt == i0 && ramCnt == r0, "R3 count", instrCnt - s0, 1);
          chk(lastInstr == VECS[k].val[15:0], "R3 value", lastInstr, VECS[k].val);
        end
        default: begin
          chk(ramCnt == r0 + 1 && idxCnt == i0 && instrCnt == s0, "R4 count", ramCnt - r0, 1);
          chk(lastRam == VECS[k].val, "R4 value", lastRam, VECS[k].val);
        end
      endcase
    end

    // R5: a single index beat changes nothing
    i0 = idxCnt;
    hostWrite(1'b0, 9'h0FE);
    chk(idxCnt == i0 && idxValue == 16'h1234, "R5 lone beat", idxValue, 16'h1234);
    // R6: chip select high drops the half pair
    csHigh();
    hostWrite(1'b0, 9'h022);
    chk(idxCnt == i0, "R6 first beat after cs", idxCnt - i0, 0);
    hostWrite(1'b0, 9'h044);
    csHigh();
    chk(idxCnt == i0 + 1 && idxValue == 16'h1122, "R6 fresh pair", idxValue, 16'h1122);

    // R7: rsel change between beats restarts pairing
    i0 = idxCnt; s0 = instrCnt;
    hostWrite(1'b0, 9'h0EE);
    hostWrite(1'b1, 9'h0B4);
    chk(instrCnt == s0 && idxCnt == i0, "R7 no strobe on switch", instrCnt - s0, 0);
    hostWrite(1'b1, 9'h14A);
    csHigh();
    chk(instrCnt == s0 + 1 && lastInstr == 16'h5AA5 && idxCnt == i0, "R7 data pair", lastInstr, 16'h5AA5);

    // R1: foreign mode ignores bus
    modeSel = 3'b010;
    tick(2);
    i0 = idxCnt;
    hostWrite(1'b0, 9'h010);
    hostWrite(1'b0, 9'h020);
    hostRead(rv, oe);
    csHigh();
    chk(idxCnt == i0 && idxValue == 16'h1122, "R1 writes ignored", idxValue, 16'h1122);
    chk(!oe, "R1 no drive", oe, 0);
    modeSel = 3'b001;
    tick(2);

    // R8/R9: reads
    csN = 1'b0;
    tick(3);
    chk(!dbOe, "R8 idle cs low", dbOe, 0);
    hostRead(rv, oe);
    chk(oe && rv == 9'h17C, "R8 upper byte", {oe, rv}, {1'b1, 9'h17C});
    hostRead(rv, oe);
    chk(oe && rv == 9'h1DE, "R8 lower byte", {oe, rv}, {1'b1, 9'h1DE});
    hostRead(rv, oe);
    chk(rv == 9'h17C, "R9 wrap to upper", rv, 9'h17C);
    csHigh();
    hostRead(rv, oe);
    chk(rv == 9'h17C, "R6 read restart", rv, 9'h17C);
    csHigh();

    chk(overlap == 0, "R10 exclusive strobes", overlap, 0);
    finishRun();
  end
endmodule